// File: doc/BRIEF.md
# PHY PLL Configuration Write Sequencer

This block programs a display PHY's PLL through the PHY's test-code register interface. A single start pulse launches a fixed, ordered series of fourteen writes. Each write pairs an 8-bit test code with an 8-bit data byte. The block takes divider, range and frequency settings that have already been computed elsewhere and turns them into those writes.

The sequence runs in this order:

- regulator bypass
- VCO range override
- input-divider override
- loop divider, sent as a low part and then a high part
- divider-override enables
- charge-pump settings, one of which depends on the target frequency
- lock-detector thresholds

After the last write is accepted, the block updates a local PHY init-control word in two steps and then pulses done.

Each write is offered on a valid/ready port. This port stands in for the electrical test interface. The settings are captured when start is accepted, so the caller may change them at any time after that.

Top module: `pll_prog_seq`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) leaves busy, done and wr_valid low and clears init_ctrl to zero.
- R2: After an accepted start, exactly fourteen writes are issued, with codes in this order: 0x1F, 0x12, 0x17, 0x18, 0x18, 0x19, 0x0E, 0x0F, 0x13, 0x1C, 0x14, 0x15, 0x16, 0x1D. The first write carries data 0x01.
- R3: The write to code 0x12 carries the 6-bit range code in bits [5:0], bit 6 set and bit 7 clear.
- R4: The write to code 0x17 carries n in bits [3:0] with the upper bits zero. The write to code 0x19 carries 0x30, which sets bits 4 and 5.
- R5: The first write to 0x18 carries m[4:0] in bits [4:0] with the upper bits zero. The second carries m[9:5] in bits [4:0] with bit 7 set and bits 6:5 clear.
- R6: The write to code 0x0E carries 0x0C when the target frequency times the post-divider is greater than 1150, and 0x0B otherwise. A product of exactly 1150 gives 0x0B.
- R7: The fixed writes carry these values: 0x0F gets 0x00, 0x13 gets 0x10, 0x1C gets 0x10, 0x14 gets 0x02, 0x15 gets 0x60, 0x16 gets 0x03, and 0x1D gets 0x02.
- R8: While wr_valid is high and wr_ready is low, the block holds wr_valid, wr_code and wr_data unchanged. A write counts as accepted only at a clock edge where wr_ready is high.
- R9: The cycle after the last write is accepted, init_ctrl is unchanged. One cycle later, init_ctrl[19:18] becomes 01. One cycle after that, bit 16 becomes 1. All other bits of init_ctrl stay zero.
- R10: done is a single-cycle pulse. It appears in the same cycle as the bit-16 update, and busy falls in that cycle.
- R11: A start pulse while busy has no effect, and changes to the settings after start is accepted have no effect. In both cases the running sequence completes with the values captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted only while idle |
| n_div | input | 4 | Input divider setting |
| m_div | input | 10 | Loop divider setting |
| vco_range | input | 6 | VCO range code |
| tgt_freq | input | 12 | Target frequency in MHz |
| post_div | input | 4 | Post-divider value |
| wr_valid | output | 1 | Write offer valid |
| wr_code | output | 8 | Test code of the offered write |
| wr_data | output | 8 | Data of the offered write |
| wr_ready | input | 1 | Downstream accepts the offered write |
| init_ctrl | output | 32 | Local PHY init-control word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step count shows on the very next offered write as a wrong code, or as a duplicated or skipped code. A wrong captured setting shows in the data byte of the write that uses it. A late or early control-word update shows as an init_ctrl value that differs within the three cycles after the last acceptance. The sweep covers every n, the edges and midpoints of m, and the charge-pump threshold on both sides. It also applies a throttled ready and restarts attempted mid-sequence, so a lost hold or a re-latch appears within one write.

// File: rtl/pll_prog_seq.sv
module pll_prog_seq #(
  parameter int N_W      = 4,
  parameter int M_W      = 10,
  parameter int RNG_W    = 6,
  parameter int FREQ_W   = 12,
  parameter int PDIV_W   = 4,
  parameter int CP_LIMIT = 1150,
  parameter int CTRL_W   = 32,
  parameter int CKSEL_LSB = 18,
  parameter int SHADOW_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_W-1:0]    n_div,
  input  logic [M_W-1:0]    m_div,
  input  logic [RNG_W-1:0]  vco_range,
  input  logic [FREQ_W-1:0] tgt_freq,
  input  logic [PDIV_W-1:0] post_div,
  output logic              wr_valid,
  output logic [7:0]        wr_code,
  output logic [7:0]        wr_data,
  input  logic              wr_ready,
  output logic [CTRL_W-1:0] init_ctrl,
  output logic              busy,
  output logic              done
);
  localparam int NUM_WR = 14;
  localparam int STEP_W = 4;
  localparam int PROD_W = FREQ_W + PDIV_W;

  logic [STEP_W-1:0] step;
  logic [N_W-1:0]    n_q;
  logic [M_W-1:0]    m_q;
  logic [RNG_W-1:0]  rng_q;
  logic              cp_hi_q;
  logic [PROD_W-1:0] prod;
  logic [7:0]        m_lo, m_hi, n_byte, rng_byte;

  assign prod     = PROD_W'(tgt_freq) * PROD_W'(post_div);
  assign wr_valid = busy && (step < STEP_W'(NUM_WR));
  assign m_lo     = 8'(m_q[4:0]);
  assign m_hi     = 8'h80 | 8'(m_q[M_W-1:5]);
  assign n_byte   = 8'(n_q);
  assign rng_byte = 8'h40 | 8'(rng_q);

  always_comb begin
    case (step)
      4'd0:    {wr_code, wr_data} = {8'h1F, 8'h01};
      4'd1:    {wr_code, wr_data} = {8'h12, rng_byte};
      4'd2:    {wr_code, wr_data} = {8'h17, n_byte};
      4'd3:    {wr_code, wr_data} = {8'h18, m_lo};
      4'd4:    {wr_code, wr_data} = {8'h18, m_hi};
      4'd5:    {wr_code, wr_data} = {8'h19, 8'h30};
      4'd6:    {wr_code, wr_data} = {8'h0E, cp_hi_q ? 8'h0C : 8'h0B};
      4'd7:    {wr_code, wr_data} = {8'h0F, 8'h00};
      4'd8:    {wr_code, wr_data} = {8'h13, 8'h10};
      4'd9:    {wr_code, wr_data} = {8'h1C, 8'h10};
      4'd10:   {wr_code, wr_data} = {8'h14, 8'h02};
      4'd11:   {wr_code, wr_data} = {8'h15, 8'h60};
      4'd12:   {wr_code, wr_data} = {8'h16, 8'h03};
      4'd13:   {wr_code, wr_data} = {8'h1D, 8'h02};
      default: {wr_code, wr_data} = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      step      <= '0;
      init_ctrl <= '0;
      n_q       <= '0;
      m_q       <= '0;
      rng_q     <= '0;
      cp_hi_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          step    <= '0;
          n_q     <= n_div;
          m_q     <= m_div;
          rng_q   <= vco_range;
          cp_hi_q <= prod > PROD_W'(CP_LIMIT);
        end
      end else if (wr_valid) begin
        if (wr_ready) step <= step + 1'b1;
      end else if (step == STEP_W'(NUM_WR)) begin
        init_ctrl[CKSEL_LSB+1:CKSEL_LSB] <= 2'b01;
        step <= step + 1'b1;
      end else begin
        init_ctrl[SHADOW_BIT] <= 1'b1;
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !wr_valid && init_ctrl == '0));

  // R8
  hold_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_code) && $stable(wr_data)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && init_ctrl[SHADOW_BIT] && init_ctrl[CKSEL_LSB+1:CKSEL_LSB] == 2'b01));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(n_q) && $stable(m_q) && $stable(rng_q)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_valid);
endmodule

// File: tb/pll_prog_seq_test.sv
module pll_prog_seq_test;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, wr_ready = 1'b0;
  logic [3:0] n_div = '0, post_div = '0;
  logic [9:0] m_div = '0;
  logic [5:0] vco_range = '0;
  logic [11:0] tgt_freq = '0;
  logic wr_valid, busy, done;
  logic [7:0] wr_code, wr_data;
  logic [31:0] init_ctrl;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [7:0] lf = 8'h5A;

  pll_prog_seq uut (.clk, .rst, .start, .n_div, .m_div, .vco_range, .tgt_freq,
    .post_div, .wr_valid, .wr_code, .wr_data, .wr_ready, .init_ctrl, .busy, .done);

  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] e_code(int i);
    logic [7:0] t [14] = '{8'h1F, 8'h12, 8'h17, 8'h18, 8'h18, 8'h19, 8'h0E,
                           8'h0F, 8'h13, 8'h1C, 8'h14, 8'h15, 8'h16, 8'h1D};
    return t[i];
  endfunction

  function automatic logic [7:0] e_data(int i, int n, int m, int r, int f, int p);
    case (i)
      0: return 8'h01;
      1: return 8'(r + 64);
      2: return 8'(n);
      3: return 8'(m % 32);
      4: return 8'(128 + m / 32);
      5: return 8'h30;
      6: return (f * p > 1150) ? 8'h0C : 8'h0B;
      7: return 8'h00;
      8: return 8'h10;
      9: return 8'h10;
      10: return 8'h02;
      11: return 8'h60;
      12: return 8'h03;
      default: return 8'h02;
    endcase
  endfunction

  function automatic string req_of(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2, 5: return "R4";
      3, 4: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run(int n, int m, int r, int f, int p, bit thr, bit inj);
    int idx = 0, guard = 0;
    bit rdy, prev_stall = 0;
    string rq;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    n_div = 4'(n); m_div = 10'(m); vco_range = 6'(r); tgt_freq = 12'(f); post_div = 4'(p);
    start = 1;
    @(negedge clk);
    start = 0;
    n_div = ~n_div; m_div = ~m_div; vco_range = ~vco_range; tgt_freq = ~tgt_freq; post_div = ~post_div;
    while (idx < 14 && guard < 400) begin
      guard++;
      rq = prev_stall ? "R8" : ((inj && idx >= 5) ? "R11" : req_of(idx));
      chk(wr_valid === 1'b1, "R8", wr_valid, 1);
      chk(wr_code === e_code(idx), prev_stall ? "R8" : "R2", wr_code, e_code(idx));
      chk(wr_data === e_data(idx, n, m, r, f, p), rq, wr_data, e_data(idx, n, m, r, f, p));
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      rdy = thr ? (lf[0] | lf[3]) : 1'b1;
      wr_ready = rdy;
      if (inj && idx == 5) begin
        start = 1;
        n_div = 4'(n + 3); m_div = 10'(m + 77); vco_range = 6'(r + 9);
        tgt_freq = 12'(f + 500); post_div = 4'(p + 5);
      end
      @(posedge clk);
      if (rdy) idx++;
      prev_stall = !rdy;
      @(negedge clk);
      start = 0;
      wr_ready = 0;
    end
    chk(wr_valid === 1'b0 && init_ctrl === 32'h0 && done === 1'b0, "R9", init_ctrl, 0);
    @(negedge clk);
    chk(init_ctrl === 32'h0004_0000 && done === 1'b0, "R9", init_ctrl, 32'h0004_0000);
    @(negedge clk);
    chk(init_ctrl === 32'h0005_0000, "R9", init_ctrl, 32'h0005_0000);
    chk(done === 1'b1 && busy === 1'b0, "R10", {done, busy}, 2'b10);
    @(negedge clk);
    chk(done === 1'b0 && wr_valid === 1'b0, "R10", done, 0);
  endtask

  initial begin
    int mv [10] = '{62, 63, 100, 255, 300, 511, 512, 623, 0, 1023};
    int fv [6] = '{1150, 1151, 575, 144, 300, 4095};
    int pv [6] = '{1, 1, 2, 8, 4, 15};
    @(negedge clk); @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && wr_valid === 1'b0 && init_ctrl === 32'h0,
        "R1", init_ctrl, 0);
    rst = 0;
    start = 0;
    @(negedge clk);
    chk(wr_valid === 1'b0 && busy === 1'b0, "R1", wr_valid, 0);
    for (int n = 0; n < 16; n++)
      for (int mi = 0; mi < 10; mi++)
        for (int k = 0; k < 6; k++)
          run(n, mv[mi], (n * 4 + mv[mi]) % 64, fv[k], pv[k], ((n + mi) % 2) == 1, k == 3);
    summary();
  end
endmodule